// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and the two issue pipes of a dual-issue core. Each clock it looks at the two oldest decoded instructions. The older one is the U candidate and the younger one is the V candidate. It decides whether both may issue in the same clock. When it refuses, only the U candidate issues, and the issue logic presents the younger instruction as the next U candidate one clock later. Each candidate arrives as a flat descriptor. The descriptor gives the instruction kind (integer, SIMD, floating point), an integer pairing class, the shared SIMD unit it needs, whether it touches memory or the integer register file, and its destination. The V slot also carries its byte length, its two sources and a flags-write bit.

When the pair is allowed and both instructions touch memory, the block compares the data-cache bank fields of the two addresses. On a match it flags a one-clock wait for the V-pipe access. It also reports when the condition codes left behind by the pair come from the V instruction. Register numbers name the full 32-bit container. A byte or word access is presented under the number of the register that holds it. All three outputs are registered, so a decision appears one clock after its descriptors.

Top module: `pair_gate`

## Requirements
- R1: With `rst` high at a clock edge, all three outputs are 0 on the next cycle. Otherwise every output reflects the descriptors sampled at the previous rising edge.
- R2: `pair_ok` is 0 unless both `u_vld` and `v_vld` are 1.
- R3: A pair is refused when U has `u_dst_en`=1 and its `u_dst` equals an enabled V source (`v_s0` with `v_s0_en`, or `v_s1` with `v_s1_en`).
- R4: A pair is refused when both destinations are enabled and equal. A V write to a register that U only reads is not presented as a U destination and does not block.
- R5: Register numbers are 32-bit containers. Two writes to different byte lanes of one register carry the same number and are refused. Different numbers never clash.
- R6: Flag writes never block a pair. `cc_from_v` is 1 exactly when the pair is accepted and `v_flags` is 1.
- R7: Kind encodings are 0 integer, 1 SIMD, 2 floating point, 3 reserved. Unit encodings are 0 none, 1 shifter, 2 multiplier, 3 state clear. Two SIMD instructions that need the same shifter (1) or multiplier (2) are refused. Shifter with multiplier may pair.
- R8: A SIMD V candidate with `v_mem` or `v_irf` set is refused. A SIMD U candidate with memory access may pair.
- R9: A SIMD state-clear instruction (unit 3) in either slot is refused. A floating-point instruction paired with a SIMD instruction, in either order, is refused.
- R10: Class encodings are 0 never, 1 either pipe, 2 U only, 3 V only (branches). Integer and floating-point U candidates need class 1 or 2. Such V candidates need class 1 or 3. The class is ignored for SIMD. Kind 3 never pairs.
- R11: A V candidate longer than `MAX_V_LEN` (7) bytes is refused. Length 7 is allowed.
- R12: `bank_wait` is 1 exactly when the pair is accepted, `u_mem` and `v_mem` are both 1, and the bank fields are equal. The bank fields `u_bank`/`v_bank` are physical address bits 4..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_vld | input | 1 | U candidate present |
| u_kind | input | 2 | U instruction kind |
| u_pcls | input | 2 | U integer pairing class |
| u_unit | input | 2 | U shared SIMD unit use |
| u_mem | input | 1 | U accesses memory |
| u_dst_en | input | 1 | U writes a register |
| u_dst | input | 4 | U destination container number |
| u_bank | input | 3 | U address bits 4..2 |
| v_vld | input | 1 | V candidate present |
| v_kind | input | 2 | V instruction kind |
| v_pcls | input | 2 | V integer pairing class |
| v_unit | input | 2 | V shared SIMD unit use |
| v_mem | input | 1 | V accesses memory |
| v_irf | input | 1 | V accesses the integer register file |
| v_len | input | 4 | V byte length |
| v_dst_en | input | 1 | V writes a register |
| v_dst | input | 4 | V destination container number |
| v_s0_en | input | 1 | V source 0 in use |
| v_s0 | input | 4 | V source 0 container number |
| v_s1_en | input | 1 | V source 1 in use |
| v_s1 | input | 4 | V source 1 container number |
| v_flags | input | 1 | V writes condition codes |
| v_bank | input | 3 | V address bits 4..2 |
| pair_ok | output | 1 | Both candidates issue together |
| bank_wait | output | 1 | V memory access delayed one clock |
| cc_from_v | output | 1 | Condition codes after the pair come from V |

## Verification
Every decision is a pure function of one clock's descriptors, so a wrong rule shows on `pair_ok` one clock after the descriptor pattern that exercises it. A dependency rule that ignores a source slot lets a flow-dependent pair through. A wrong bank slice produces a wrong `bank_wait` on the very next cycle. A stale or mis-reset output register shows as an output that lags or leads the prediction by a cycle. Directed patterns hit each refusal cause and its boundary on their own. A long random stream with few distinct register numbers then mixes the causes.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int REG_W  = 4;
  localparam int LEN_W  = 4;
  localparam int BANK_W = 3;

  typedef enum logic [1:0] {K_INT = 2'd0, K_SIMD = 2'd1, K_FP = 2'd2, K_RSV = 2'd3} kind_e;
  typedef enum logic [1:0] {C_NEVER = 2'd0, C_ANY = 2'd1, C_UONLY = 2'd2, C_VONLY = 2'd3} pcls_e;
  typedef enum logic [1:0] {N_NONE = 2'd0, N_SHIFT = 2'd1, N_MUL = 2'd2, N_CLEAR = 2'd3} unit_e;
endpackage

// File: rtl/pair_slot.sv
// Per-slot legality: may this instruction occupy the given pipe in a pair?
module pair_slot
  import pair_pkg::*;
#(
  parameter bit IS_V      = 1'b0,
  parameter int MAX_V_LEN = 7
) (
  input  logic             vld,
  input  logic [1:0]       kind,
  input  logic [1:0]       pcls,
  input  logic [1:0]       unit,
  input  logic             ext_acc,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_V_LEN);

  logic class_ok;

  generate
    if (IS_V) begin : g_v
      assign class_ok = (pcls == C_ANY) || (pcls == C_VONLY);
    end else begin : g_u
      assign class_ok = (pcls == C_ANY) || (pcls == C_UONLY);
    end
  endgenerate

  always_comb begin
    ok = vld;
    unique case (kind)
      K_INT, K_FP: ok = ok & class_ok;
      K_SIMD: begin
        if (unit == N_CLEAR) ok = 1'b0;
        if (IS_V && ext_acc) ok = 1'b0;
      end
      default: ok = 1'b0;
    endcase
    if (IS_V && (len > LEN_LIM)) ok = 1'b0;
  end
endmodule

// File: rtl/pair_hazard.sv
// Cross-slot conflicts: register contention, shared units, FP/SIMD mixing.
module pair_hazard
  import pair_pkg::*;
(
  input  logic [1:0]       u_kind,
  input  logic [1:0]       u_unit,
  input  logic             u_dst_en,
  input  logic [REG_W-1:0] u_dst,
  input  logic [1:0]       v_kind,
  input  logic [1:0]       v_unit,
  input  logic             v_dst_en,
  input  logic [REG_W-1:0] v_dst,
  input  logic             v_s0_en,
  input  logic [REG_W-1:0] v_s0,
  input  logic             v_s1_en,
  input  logic [REG_W-1:0] v_s1,
  output logic             clash
);
  logic flow_dep, out_dep, unit_dep, mix_dep, both_simd;

  always_comb begin
    flow_dep  = u_dst_en && ((v_s0_en && (v_s0 == u_dst)) || (v_s1_en && (v_s1 == u_dst)));
    out_dep   = u_dst_en && v_dst_en && (u_dst == v_dst);
    both_simd = (u_kind == K_SIMD) && (v_kind == K_SIMD);
    unit_dep  = both_simd && (u_unit == v_unit) && ((u_unit == N_SHIFT) || (u_unit == N_MUL));
    mix_dep   = ((u_kind == K_FP) && (v_kind == K_SIMD)) || ((u_kind == K_SIMD) && (v_kind == K_FP));
    clash     = flow_dep | out_dep | unit_dep | mix_dep;
  end
endmodule

// File: rtl/pair_bank.sv
// Data-cache bank comparison of the two memory accesses.
module pair_bank
  import pair_pkg::*;
(
  input  logic              u_mem,
  input  logic              v_mem,
  input  logic [BANK_W-1:0] u_bank,
  input  logic [BANK_W-1:0] v_bank,
  output logic              hit
);
  assign hit = u_mem & v_mem & (u_bank == v_bank);
endmodule

// File: rtl/pair_gate.sv
module pair_gate
  import pair_pkg::*;
#(
  parameter int MAX_V_LEN = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              u_vld,
  input  logic [1:0]        u_kind,
  input  logic [1:0]        u_pcls,
  input  logic [1:0]        u_unit,
  input  logic              u_mem,
  input  logic              u_dst_en,
  input  logic [REG_W-1:0]  u_dst,
  input  logic [BANK_W-1:0] u_bank,
  input  logic              v_vld,
  input  logic [1:0]        v_kind,
  input  logic [1:0]        v_pcls,
  input  logic [1:0]        v_unit,
  input  logic              v_mem,
  input  logic              v_irf,
  input  logic [LEN_W-1:0]  v_len,
  input  logic              v_dst_en,
  input  logic [REG_W-1:0]  v_dst,
  input  logic              v_s0_en,
  input  logic [REG_W-1:0]  v_s0,
  input  logic              v_s1_en,
  input  logic [REG_W-1:0]  v_s1,
  input  logic              v_flags,
  input  logic [BANK_W-1:0] v_bank,
  output logic              pair_ok,
  output logic              bank_wait,
  output logic              cc_from_v
);
  logic u_fit, v_fit, conflict, same_bank, pair_c;

  pair_slot #(.IS_V(1'b0), .MAX_V_LEN(MAX_V_LEN)) u_slot (
    .vld(u_vld), .kind(u_kind), .pcls(u_pcls), .unit(u_unit),
    .ext_acc(1'b0), .len('0), .ok(u_fit)
  );

  pair_slot #(.IS_V(1'b1), .MAX_V_LEN(MAX_V_LEN)) v_slot (
    .vld(v_vld), .kind(v_kind), .pcls(v_pcls), .unit(v_unit),
    .ext_acc(v_mem | v_irf), .len(v_len), .ok(v_fit)
  );

  pair_hazard hz (
    .u_kind(u_kind), .u_unit(u_unit), .u_dst_en(u_dst_en), .u_dst(u_dst),
    .v_kind(v_kind), .v_unit(v_unit), .v_dst_en(v_dst_en), .v_dst(v_dst),
    .v_s0_en(v_s0_en), .v_s0(v_s0), .v_s1_en(v_s1_en), .v_s1(v_s1),
    .clash(conflict)
  );

  pair_bank bk (
    .u_mem(u_mem), .v_mem(v_mem), .u_bank(u_bank), .v_bank(v_bank), .hit(same_bank)
  );

  assign pair_c = u_fit & v_fit & ~conflict;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_ok   <= 1'b0;
      bank_wait <= 1'b0;
      cc_from_v <= 1'b0;
    end else begin
      pair_ok   <= pair_c;
      bank_wait <= pair_c & same_bank;
      cc_from_v <= pair_c & v_flags;
    end
  end
endmodule

// File: rtl/pair_gate_chk.sv
module pair_gate_chk
  import pair_pkg::*;
#(
  parameter int MAX_V_LEN = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             u_vld,
  input logic             v_vld,
  input logic [1:0]       u_kind,
  input logic [1:0]       u_unit,
  input logic             u_dst_en,
  input logic [REG_W-1:0] u_dst,
  input logic [1:0]       v_kind,
  input logic             v_mem,
  input logic [LEN_W-1:0] v_len,
  input logic             v_dst_en,
  input logic [REG_W-1:0] v_dst,
  input logic             v_s0_en,
  input logic [REG_W-1:0] v_s0,
  input logic             pair_ok,
  input logic             bank_wait,
  input logic             cc_from_v
);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_V_LEN);

  assert_need_both_R2: assert property (@(posedge clk) disable iff (rst)
    (!u_vld || !v_vld) |=> !pair_ok);

  assert_flow_dep_R3: assert property (@(posedge clk) disable iff (rst)
    (u_dst_en && v_s0_en && (u_dst == v_s0)) |=> !pair_ok);

  assert_out_dep_R4: assert property (@(posedge clk) disable iff (rst)
    (u_dst_en && v_dst_en && (u_dst == v_dst)) |=> !pair_ok);

  assert_cc_needs_pair_R6: assert property (@(posedge clk) disable iff (rst)
    cc_from_v |-> pair_ok);

  assert_v_simd_mem_R8: assert property (@(posedge clk) disable iff (rst)
    ((v_kind == 2'd1) && v_mem) |=> !pair_ok);

  assert_clear_alone_R9: assert property (@(posedge clk) disable iff (rst)
    ((u_kind == 2'd1) && (u_unit == 2'd3)) |=> !pair_ok);

  assert_long_v_R11: assert property (@(posedge clk) disable iff (rst)
    (v_len > LEN_LIM) |=> !pair_ok);

  assert_wait_needs_pair_R12: assert property (@(posedge clk) disable iff (rst)
    bank_wait |-> pair_ok);
endmodule

bind pair_gate pair_gate_chk #(.MAX_V_LEN(MAX_V_LEN)) chk (
  .clk(clk), .rst(rst), .u_vld(u_vld), .v_vld(v_vld), .u_kind(u_kind),
  .u_unit(u_unit), .u_dst_en(u_dst_en), .u_dst(u_dst), .v_kind(v_kind),
  .v_mem(v_mem), .v_len(v_len), .v_dst_en(v_dst_en), .v_dst(v_dst),
  .v_s0_en(v_s0_en), .v_s0(v_s0), .pair_ok(pair_ok), .bank_wait(bank_wait),
  .cc_from_v(cc_from_v)
);

// File: tb/pair_gate_test.sv
module pair_gate_test;
  typedef struct {
    logic       vld;
    logic [1:0] kind, pcls, unit;
    logic       mem, irf;
    logic [3:0] len;
    logic       dst_en;
    logic [3:0] dst;
    logic       s0_en;
    logic [3:0] s0;
    logic       s1_en;
    logic [3:0] s1;
    logic       flags;
    logic [2:0] bank;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  ins_t du, dv;
  logic pair_ok, bank_wait, cc_from_v;
  logic [2:0] exp_out;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pair_gate uut (
    .clk(clk), .rst(rst),
    .u_vld(du.vld), .u_kind(du.kind), .u_pcls(du.pcls), .u_unit(du.unit),
    .u_mem(du.mem), .u_dst_en(du.dst_en), .u_dst(du.dst), .u_bank(du.bank),
    .v_vld(dv.vld), .v_kind(dv.kind), .v_pcls(dv.pcls), .v_unit(dv.unit),
    .v_mem(dv.mem), .v_irf(dv.irf), .v_len(dv.len), .v_dst_en(dv.dst_en),
    .v_dst(dv.dst), .v_s0_en(dv.s0_en), .v_s0(dv.s0), .v_s1_en(dv.s1_en),
    .v_s1(dv.s1), .v_flags(dv.flags), .v_bank(dv.bank),
    .pair_ok(pair_ok), .bank_wait(bank_wait), .cc_from_v(cc_from_v)
  );

  function automatic ins_t plain(input logic [3:0] d);
    ins_t r;
    r.vld = 1; r.kind = 0; r.pcls = 1; r.unit = 0; r.mem = 0; r.irf = 0;
    r.len = 4'd2; r.dst_en = 1; r.dst = d; r.s0_en = 0; r.s0 = 0;
    r.s1_en = 0; r.s1 = 0; r.flags = 0; r.bank = 0;
    return r;
  endfunction

  function automatic ins_t simd(input logic [3:0] d, input logic [1:0] un);
    ins_t r = plain(d);
    r.kind = 2'd1; r.pcls = 2'd0; r.unit = un;
    return r;
  endfunction

  // Reference: {pair, bank wait, cc from V}
  function automatic logic [2:0] predict(input ins_t u, input ins_t v);
    bit go = u.vld && v.vld;
    if (u.kind == 3 || v.kind == 3) go = 0;
    if (u.kind != 1 && !(u.pcls == 1 || u.pcls == 2)) go = 0;
    if (v.kind != 1 && !(v.pcls == 1 || v.pcls == 3)) go = 0;
    if (v.len > 7) go = 0;
    if ((u.kind == 1 && u.unit == 3) || (v.kind == 1 && v.unit == 3)) go = 0;
    if (v.kind == 1 && (v.mem || v.irf)) go = 0;
    if ((u.kind == 2 && v.kind == 1) || (u.kind == 1 && v.kind == 2)) go = 0;
    if (u.kind == 1 && v.kind == 1 && u.unit == v.unit && u.unit != 0) go = 0;
    if (u.dst_en && v.s0_en && v.s0 == u.dst) go = 0;
    if (u.dst_en && v.s1_en && v.s1 == u.dst) go = 0;
    if (u.dst_en && v.dst_en && v.dst == u.dst) go = 0;
    return {go, go && u.mem && v.mem && (u.bank == v.bank), go && v.flags};
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if ({pair_ok, bank_wait, cc_from_v} !== exp_out) begin
      n_bad++;
      $display("FAIL %s: got pair/wait/cc=%b%b%b expected %b", tag,
               pair_ok, bank_wait, cc_from_v, exp_out);
    end
  endtask

  // drive at a falling edge, register at the rising edge, sample at the next falling edge
  task automatic apply(input ins_t u, input ins_t v, input string tag);
    du = u; dv = v;
    exp_out = predict(u, v);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ins_t a, b;
    du = plain(4'd1); dv = plain(4'd2);
    repeat (3) @(negedge clk);
    exp_out = 3'b000;
    compare("R1 reset state");
    rst = 1'b0;

    apply(plain(1), plain(2), "R10 basic pair");
    a = plain(1); b = plain(2); b.s0_en = 1; b.s0 = 1;
    apply(a, b, "R3 flow via s0");
    b = plain(2); b.s1_en = 1; b.s1 = 1;
    apply(a, b, "R3 flow via s1");
    b = plain(2); b.s0_en = 1; b.s0 = 5;
    apply(a, b, "R3 unrelated source");
    apply(plain(1), plain(1), "R4 output dependence");
    a = plain(1); a.dst_en = 0; b = plain(1);
    apply(a, b, "R4 V writes register U only reads");
    apply(plain(3), plain(3), "R5 byte lanes of one container");
    apply(plain(3), plain(4), "R5 distinct containers");
    a = plain(1); a.pcls = 2; b = plain(2); b.flags = 1;
    apply(a, b, "R6 both flag writers pair, cc from V");
    b.flags = 0;
    apply(a, b, "R6 only U writes flags");
    apply(simd(8, 1), simd(9, 1), "R7 two shifter users");
    apply(simd(8, 2), simd(9, 2), "R7 two multiplier users");
    apply(simd(8, 1), simd(9, 2), "R7 shifter with multiplier");
    b = simd(9, 0); b.mem = 1;
    apply(simd(8, 0), b, "R8 V SIMD memory");
    b = simd(9, 0); b.irf = 1;
    apply(simd(8, 0), b, "R8 V SIMD int file");
    a = simd(8, 0); a.mem = 1;
    apply(a, simd(9, 0), "R8 U SIMD memory allowed");
    apply(simd(8, 3), plain(2), "R9 clear in U");
    apply(plain(2), simd(8, 3), "R9 clear in V");
    a = plain(1); a.kind = 2;
    apply(a, simd(9, 0), "R9 FP then SIMD");
    b = plain(1); b.kind = 2;
    apply(simd(9, 0), b, "R9 SIMD then FP");
    a = plain(1); a.pcls = 3;
    apply(a, plain(2), "R10 V-only class in U");
    b = plain(2); b.pcls = 3;
    apply(plain(1), b, "R10 branch in V pairs");
    b = plain(2); b.pcls = 2;
    apply(plain(1), b, "R10 U-only class in V");
    b = plain(2); b.pcls = 0;
    apply(plain(1), b, "R10 never class");
    a = plain(1); a.kind = 3;
    apply(a, plain(2), "R10 reserved kind");
    b = plain(2); b.len = 8;
    apply(plain(1), b, "R11 eight byte V");
    b.len = 7;
    apply(plain(1), b, "R11 seven byte V");
    a = plain(1); a.mem = 1; a.bank = 3'd1; b = plain(2); b.mem = 1; b.bank = 3'd1;
    apply(a, b, "R12 same bank");
    b.bank = 3'd2;
    apply(a, b, "R12 different bank");
    b.bank = 3'd1; b.mem = 0;
    apply(a, b, "R12 one memory access");
    b.mem = 1; b.s0_en = 1; b.s0 = 1;
    apply(a, b, "R12 refused pair no wait");
    b = plain(2); b.vld = 0;
    apply(plain(1), b, "R2 V absent");
    a = plain(1); a.vld = 0;
    apply(a, plain(2), "R2 U absent");

    for (int i = 0; i < 600; i++) begin
      a.vld = ($urandom_range(0, 7) != 0); a.kind = 2'($urandom_range(0, 3));
      a.pcls = 2'($urandom_range(0, 3)); a.unit = 2'($urandom_range(0, 3));
      a.mem = 1'($urandom_range(0, 1)); a.irf = 0; a.len = 0;
      a.dst_en = 1'($urandom_range(0, 1)); a.dst = 4'($urandom_range(0, 3));
      a.s0_en = 0; a.s0 = 0; a.s1_en = 0; a.s1 = 0; a.flags = 0;
      a.bank = 3'($urandom_range(0, 3));
      b.vld = ($urandom_range(0, 7) != 0); b.kind = 2'($urandom_range(0, 3));
      b.pcls = 2'($urandom_range(0, 3)); b.unit = 2'($urandom_range(0, 3));
      b.mem = 1'($urandom_range(0, 1)); b.irf = 1'($urandom_range(0, 1));
      b.len = 4'($urandom_range(1, 9)); b.dst_en = 1'($urandom_range(0, 1));
      b.dst = 4'($urandom_range(0, 3)); b.s0_en = 1'($urandom_range(0, 1));
      b.s0 = 4'($urandom_range(0, 3)); b.s1_en = 1'($urandom_range(0, 1));
      b.s1 = 4'($urandom_range(0, 3)); b.flags = 1'($urandom_range(0, 1));
      b.bank = 3'($urandom_range(0, 3));
      apply(a, b, "random mix");
    end

    rst = 1'b1;
    du = plain(1); dv = plain(2);
    exp_out = 3'b000;
    @(negedge clk);
    compare("R1 reset mid-run");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule